// File: doc/BRIEF.md
# Receive Ring Pointer Controller

This block holds the control and status state of one receive DMA channel that stores incoming bytes in a circular buffer in memory. Software programs the buffer base, its length, both pointers and a fill threshold through a simple register write port. The block then advances the write pointer for every byte the memory path accepts and presents the memory address of the next byte. It reports how many unread bytes the ring holds and raises threshold and completion interrupts.

Each pointer carries a wrap bit beside its offset, so equal offsets can mean either an empty ring or a full one. The channel can be halted in two ways: clearing the run bit stops it at once, while a graceful stop request lets the current transaction (a run of bytes ended by `in_last`) finish first. A flush request waits for the same transaction boundary and then reports completion. A warm reset drops the channel to idle and leaves the pointers in place, so software can reprogram them.

Top module: `rxring_dma_ctl`

## Requirements
- R1: After reset the channel is disabled (`run_en`=0, `in_ready`=0), both pointers read 0, `valid_cnt` is 0, both flags are 0 and `irq` is 0.
- R2: Each accepted byte (`in_valid` and `in_ready` at a clock edge) moves the write offset forward by one. `mem_addr` equals the base (register 2) plus the write offset. When the offset reaches length-1 it restarts at 0 and the wrap bit (pointer bit 31) inverts.
- R3: `valid_cnt` is the write offset minus the read offset when the wrap bits match. When they differ it is the write offset plus the length minus the read offset.
- R4: A software write of register 5 (offset in the low bits, wrap in bit 31) replaces the read pointer. `valid_cnt` and `data_pending` follow from the next cycle on.
- R5: When the offsets are equal and the wrap bits differ, the ring is full: `in_ready` is 0 and the write pointer does not move.
- R6: Writing 0 to bit 0 of register 0 disables the channel at the next edge, even inside a transaction. From then on no byte is accepted.
- R7: Writing 1 to bit 0 of register 1 while enabled sets `stop_busy`. Bytes are still accepted until one with `in_last` is taken. At the next edge `stop_busy` and `run_en` clear and the done flag sets. The request is ignored while the channel is disabled.
- R8: Bit 1 of register 1 requests a flush. `flush_busy` holds until no transaction is open, then clears and sets the done flag. The request is ignored while a stop is pending or is written together with a stop. A stop request cancels a pending flush, so both are never busy at once.
- R9: Bit 2 of register 1 (warm reset) clears `run_en`, `stop_busy` and `flush_busy` at the next edge and leaves both pointers unchanged.
- R10: The threshold flag sets when `valid_cnt` is nonzero and at least the threshold (register 6). The done flag sets on stop or flush completion. Writing 1 to register 7 bit 0 clears the threshold flag, and bit 1 clears the done flag.
- R11: `irq` is the OR of each flag ANDed with its enable (register 8, bit 0 threshold, bit 1 done), registered one cycle after the flags.
- R12: Register 3 sets the length. A write of 0 or of more than 2^AW is ignored. Register 4 replaces the write pointer in the same format as register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | DW | Register write data |
| in_valid | input | 1 | A received byte is offered to memory |
| in_last | input | 1 | Offered byte ends the current transaction |
| in_ready | output | 1 | Byte is accepted this cycle |
| mem_addr | output | ADDR_W | Memory address for the offered byte |
| wr_ptr | output | DW | Write pointer, wrap in bit DW-1 |
| rd_ptr | output | DW | Read pointer, wrap in bit DW-1 |
| valid_cnt | output | AW+1 | Unread bytes in the ring |
| data_pending | output | 1 | Ring holds unread data |
| run_en | output | 1 | Channel enabled |
| stop_busy | output | 1 | Graceful stop pending |
| flush_busy | output | 1 | Flush pending |
| flag_thr | output | 1 | Threshold flag |
| flag_done | output | 1 | Stop or flush completion flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted offset or wrap bit appears on `wr_ptr` and `mem_addr` in the cycle after the byte that caused it. A wrong full or empty decision appears on `valid_cnt` and `in_ready` in that same cycle, so the checks compare these against a pointer model after every byte and every pointer write. Faults in the stop and flush sequencing show up one edge after the closing byte, as a busy bit that stays set, a missing done flag, or an `irq` one cycle late. The tests therefore sample exactly those cycles around each transaction boundary.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
   typedef enum logic [3:0] {
      RA_RUN  = 4'd0,
      RA_CMD  = 4'd1,
      RA_BASE = 4'd2,
      RA_LEN  = 4'd3,
      RA_WPTR = 4'd4,
      RA_RPTR = 4'd5,
      RA_THR  = 4'd6,
      RA_FLAG = 4'd7,
      RA_IEN  = 4'd8
   } reg_addr_e;

   localparam int CMD_STOP  = 0;
   localparam int CMD_FLUSH = 1;
   localparam int CMD_WARM  = 2;
   localparam int FLG_THR   = 0;
   localparam int FLG_DONE  = 1;
endpackage

// File: rtl/rxring_ptr.sv
module rxring_ptr #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          ld,
   input  logic [AW-1:0] ld_off,
   input  logic          ld_wrap,
   input  logic [AW:0]   len,
   output logic [AW-1:0] off,
   output logic          wrap
);
   logic at_end;
   assign at_end = ({1'b0, off} + (AW+1)'(1)) >= len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off  <= '0;
         wrap <= 1'b0;
      end else if (ld) begin
         off  <= ld_off;
         wrap <= ld_wrap;
      end else if (adv) begin
         if (at_end) begin
            off  <= '0;
            wrap <= ~wrap;
         end else begin
            off <= off + AW'(1);
         end
      end
   end
endmodule

// File: rtl/rxring_level.sv
module rxring_level #(
   parameter int AW = 8
) (
   input  logic [AW-1:0] w_off,
   input  logic          w_wrap,
   input  logic [AW-1:0] r_off,
   input  logic          r_wrap,
   input  logic [AW:0]   len,
   input  logic [AW:0]   thr,
   output logic [AW:0]   cnt,
   output logic          full,
   output logic          pending,
   output logic          thr_hit
);
   logic same_lap;
   assign same_lap = (w_wrap == r_wrap);

   always_comb begin
      if (same_lap) cnt = {1'b0, w_off} - {1'b0, r_off};
      else          cnt = {1'b0, w_off} + len - {1'b0, r_off};
   end

   assign full    = (w_off == r_off) && !same_lap;
   assign pending = (cnt != '0) || (w_off != r_off) || !same_lap;
   assign thr_hit = (cnt != '0) && (cnt >= thr);
endmodule

// File: rtl/rxring_ctl.sv
module rxring_ctl
   import rxring_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [3:0] addr,
   input  logic [2:0] wd,
   input  logic       in_valid,
   input  logic       in_last,
   input  logic       full,
   input  logic       thr_hit,
   output logic       in_ready,
   output logic       acc,
   output logic       en,
   output logic       stop_pend,
   output logic       flush_pend,
   output logic       flag_thr,
   output logic       flag_done,
   output logic       irq
);
   logic wr_run, wr_cmd, wr_flag, wr_ien;
   logic in_burst, stop_done, flush_done, warm, stop_req, run_off;
   logic [1:0] ien;
   logic irq_c;

   assign wr_run  = we && (addr == RA_RUN);
   assign wr_cmd  = we && (addr == RA_CMD);
   assign wr_flag = we && (addr == RA_FLAG);
   assign wr_ien  = we && (addr == RA_IEN);

   assign warm     = wr_cmd && wd[CMD_WARM];
   assign stop_req = wr_cmd && wd[CMD_STOP] && en;
   assign run_off  = wr_run && !wd[0];

   assign stop_done  = stop_pend && !in_burst;
   assign flush_done = flush_pend && !in_burst;
   assign in_ready   = en && !full && !stop_done;
   assign acc        = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en         <= 1'b0;
         stop_pend  <= 1'b0;
         flush_pend <= 1'b0;
         in_burst   <= 1'b0;
      end else if (warm) begin
         en         <= 1'b0;
         stop_pend  <= 1'b0;
         flush_pend <= 1'b0;
         in_burst   <= 1'b0;
      end else begin
         if (wr_run)         en <= wd[0];
         else if (stop_done) en <= 1'b0;

         if (run_off)        stop_pend <= 1'b0;
         else if (stop_req)  stop_pend <= 1'b1;
         else if (stop_done) stop_pend <= 1'b0;

         if (stop_req)                                     flush_pend <= 1'b0;
         else if (wr_cmd && wd[CMD_FLUSH] && !stop_pend)   flush_pend <= 1'b1;
         else if (flush_done)                              flush_pend <= 1'b0;

         if (run_off)  in_burst <= 1'b0;
         else if (acc) in_burst <= !in_last;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_thr  <= 1'b0;
         flag_done <= 1'b0;
         ien       <= 2'b00;
      end else begin
         flag_thr  <= thr_hit || (flag_thr && !(wr_flag && wd[FLG_THR]));
         flag_done <= (stop_done || flush_done) ||
                      (flag_done && !(wr_flag && wd[FLG_DONE]));
         if (wr_ien) ien <= wd[1:0];
      end
   end

   assign irq_c = (flag_thr && ien[FLG_THR]) || (flag_done && ien[FLG_DONE]);

   generate
      if (IRQ_REG) begin : g_irq_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_c;
         end
      end else begin : g_irq_comb
         assign irq = irq_c;
      end
   endgenerate
endmodule

// File: rtl/rxring_dma_ctl.sv
module rxring_dma_ctl
   import rxring_pkg::*;
#(
   parameter int AW      = 8,
   parameter int DW      = 32,
   parameter int ADDR_W  = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DW-1:0]     wr_ptr,
   output logic [DW-1:0]     rd_ptr,
   output logic [AW:0]       valid_cnt,
   output logic              data_pending,
   output logic              run_en,
   output logic              stop_busy,
   output logic              flush_busy,
   output logic              flag_thr,
   output logic              flag_done,
   output logic              irq
);
   localparam int          WRAP_BIT = DW - 1;
   localparam int          PAD_W    = DW - 1 - AW;
   localparam logic [AW:0] LEN_MAX  = (AW+1)'(1) << AW;

   generate
      if (AW < 2 || PAD_W < 1 || ADDR_W < AW || DW < ADDR_W) begin : g_bad_cfg
         $error("rxring_dma_ctl: parameter set out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q;
   logic [AW:0]       len_q, thr_q;
   logic              len_ok, wptr_ld, rptr_ld, acc, full, thr_hit;
   logic [AW-1:0]     w_off, r_off;
   logic              w_wrap, r_wrap;

   assign len_ok  = (reg_wdata != '0) && (reg_wdata <= DW'(LEN_MAX));
   assign wptr_ld = reg_we && (reg_addr == RA_WPTR);
   assign rptr_ld = reg_we && (reg_addr == RA_RPTR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         len_q  <= LEN_MAX;
         thr_q  <= (AW+1)'(1);
      end else if (reg_we) begin
         if (reg_addr == RA_BASE)           base_q <= reg_wdata[ADDR_W-1:0];
         if (reg_addr == RA_LEN && len_ok)  len_q  <= reg_wdata[AW:0];
         if (reg_addr == RA_THR)            thr_q  <= reg_wdata[AW:0];
      end
   end

   rxring_ptr #(.AW(AW)) i_wptr (
      .clk(clk), .rst_n(rst_n), .adv(acc), .ld(wptr_ld),
      .ld_off(reg_wdata[AW-1:0]), .ld_wrap(reg_wdata[WRAP_BIT]),
      .len(len_q), .off(w_off), .wrap(w_wrap)
   );

   rxring_ptr #(.AW(AW)) i_rptr (
      .clk(clk), .rst_n(rst_n), .adv(1'b0), .ld(rptr_ld),
      .ld_off(reg_wdata[AW-1:0]), .ld_wrap(reg_wdata[WRAP_BIT]),
      .len(len_q), .off(r_off), .wrap(r_wrap)
   );

   rxring_level #(.AW(AW)) i_level (
      .w_off(w_off), .w_wrap(w_wrap), .r_off(r_off), .r_wrap(r_wrap),
      .len(len_q), .thr(thr_q), .cnt(valid_cnt), .full(full),
      .pending(data_pending), .thr_hit(thr_hit)
   );

   rxring_ctl #(.IRQ_REG(IRQ_REG)) i_ctl (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wd(reg_wdata[2:0]), .in_valid(in_valid), .in_last(in_last),
      .full(full), .thr_hit(thr_hit), .in_ready(in_ready), .acc(acc),
      .en(run_en), .stop_pend(stop_busy), .flush_pend(flush_busy),
      .flag_thr(flag_thr), .flag_done(flag_done), .irq(irq)
   );

   assign mem_addr = base_q + ADDR_W'(w_off);
   assign wr_ptr   = {w_wrap, {PAD_W{1'b0}}, w_off};
   assign rd_ptr   = {r_wrap, {PAD_W{1'b0}}, r_off};
endmodule

// File: rtl/rxring_dma_ctl_chk.sv
module rxring_dma_ctl_chk #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW:0]   valid_cnt,
   input logic [AW:0]   len_q,
   input logic          full,
   input logic          in_ready,
   input logic          run_en,
   input logic          stop_busy,
   input logic          flush_busy,
   input logic [DW-1:0] wr_ptr,
   input logic          acc,
   input logic          wptr_ld,
   input logic          irq,
   input logic          flag_thr,
   input logic          flag_done
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |-> (valid_cnt <= len_q)); // R3

   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !in_ready); // R5

   AST_STOP_FLUSH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop_busy && flush_busy)); // R8

   AST_WPTR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_ptr) |-> $past(acc || wptr_ld)); // R2

   AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_thr || flag_done || $past(flag_thr || flag_done))); // R11

   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_done) |-> $past(stop_busy || flush_busy)); // R7
endmodule

bind rxring_dma_ctl rxring_dma_ctl_chk #(.AW(AW), .DW(DW)) i_chk (
   .clk(clk), .rst_n(rst_n), .valid_cnt(valid_cnt), .len_q(len_q),
   .full(full), .in_ready(in_ready), .run_en(run_en), .stop_busy(stop_busy),
   .flush_busy(flush_busy), .wr_ptr(wr_ptr), .acc(acc), .wptr_ld(wptr_ld),
   .irq(irq), .flag_thr(flag_thr), .flag_done(flag_done)
);

// File: tb/test_rxring_dma_ctl.sv
module test_rxring_dma_ctl;
   import rxring_pkg::*;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic          in_valid = 1'b0, in_last = 1'b0;
   logic          in_ready, data_pending, run_en, stop_busy, flush_busy;
   logic          flag_thr, flag_done, irq;
   logic [31:0]   mem_addr;
   logic [DW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   valid_cnt;

   int n_chk = 0, n_err = 0;
   int m_wo = 0, m_ww = 0, m_ro = 0, m_rw = 0, m_len = 256;
   int m_base = 0;
   bit done_run = 0;

   always #2 clk = ~clk;

   rxring_dma_ctl i_rxring_dma_ctl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .in_valid(in_valid), .in_last(in_last),
      .in_ready(in_ready), .mem_addr(mem_addr), .wr_ptr(wr_ptr),
      .rd_ptr(rd_ptr), .valid_cnt(valid_cnt), .data_pending(data_pending),
      .run_en(run_en), .stop_busy(stop_busy), .flush_busy(flush_busy),
      .flag_thr(flag_thr), .flag_done(flag_done), .irq(irq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_cnt();
      return (m_ww == m_rw) ? (m_wo - m_ro) : (m_wo + m_len - m_ro);
   endfunction

   function automatic logic [31:0] exp_wptr();
      return {m_ww[0], 31'(m_wo)};
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input reg_addr_e a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a == RA_RPTR) begin m_ro = int'(d[AW-1:0]); m_rw = int'(d[31]); end
      if (a == RA_WPTR) begin m_wo = int'(d[AW-1:0]); m_ww = int'(d[31]); end
   endtask

   task automatic push(input logic last);
      logic rdy;
      @(negedge clk);
      in_valid = 1'b1; in_last = last; rdy = in_ready;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if (rdy) begin
         m_wo++;
         if (m_wo >= m_len) begin m_wo = 0; m_ww ^= 1; end
      end
   endtask

   task automatic drain();
      wr(RA_RPTR, wr_ptr);
   endtask

   task automatic t_reset();
      chk(run_en, 0, "R1 run_en");
      chk(in_ready, 0, "R1 in_ready");
      chk(wr_ptr, 0, "R1 wr_ptr");
      chk(rd_ptr, 0, "R1 rd_ptr");
      chk(valid_cnt, 0, "R1 valid_cnt");
      chk({flag_thr, flag_done, irq}, 0, "R1 flags/irq");
   endtask

   task automatic t_fill();
      wr(RA_BASE, 32'h1000); m_base = 32'h1000;
      wr(RA_LEN, 4); m_len = 4;
      wr(RA_THR, 3);
      wr(RA_IEN, 1);
      wr(RA_RUN, 1);
      chk(in_ready, 1, "R2 ready when enabled");
      chk(mem_addr, 32'h1000, "R2 mem_addr base");
      for (int i = 0; i < 3; i++) begin
         push(1'b0);
         chk(valid_cnt, exp_cnt(), "R3 count while filling");
         chk(mem_addr, m_base + m_wo, "R2 mem_addr offset");
      end
      chk(flag_thr, 0, "R10 threshold flag not yet");
      tick();
      chk(flag_thr, 1, "R10 threshold flag set");
      chk(irq, 0, "R11 irq one cycle after flag");
      tick();
      chk(irq, 1, "R11 irq raised");
      push(1'b1);
      chk(wr_ptr, 32'h8000_0000, "R2 wrap bit toggles at end");
      chk(valid_cnt, 4, "R3 full count");
      chk(in_ready, 0, "R5 not ready when full");
      push(1'b0);
      chk(wr_ptr, 32'h8000_0000, "R5 pointer held when full");
      wr(RA_RPTR, 2);
      chk(valid_cnt, exp_cnt(), "R4 count after read pointer write");
      chk(data_pending, 1, "R4 pending");
      wr(RA_RPTR, 32'h8000_0000);
      chk(valid_cnt, 0, "R4 empty after read pointer write");
      chk(data_pending, 0, "R4 nothing pending");
      wr(RA_FLAG, 1);
      chk(flag_thr, 0, "R10 threshold flag cleared");
      tick();
      chk(irq, 0, "R11 irq drops");
      push(1'b1);
      chk(valid_cnt, 1, "R3 same-lap count");
      chk(mem_addr, 32'h1001, "R2 mem_addr after wrap");
      wr(RA_RPTR, 3);
      chk(valid_cnt, exp_cnt(), "R3 cross-lap count");
      drain();
   endtask

   task automatic t_halt();
      push(1'b0);
      wr(RA_RUN, 0);
      chk(run_en, 0, "R6 disabled at once");
      chk(in_ready, 0, "R6 not ready");
      push(1'b0);
      chk(wr_ptr, exp_wptr(), "R6 no byte taken");
      drain();
   endtask

   task automatic t_stop();
      wr(RA_RUN, 1);
      push(1'b0);
      wr(RA_CMD, 1);
      chk(stop_busy, 1, "R7 stop pending");
      chk(in_ready, 1, "R7 still accepting mid-transaction");
      push(1'b1);
      chk(wr_ptr, exp_wptr(), "R7 closing byte taken");
      chk(stop_busy, 1, "R7 stop still pending");
      tick();
      chk(stop_busy, 0, "R7 stop self-clears");
      chk(run_en, 0, "R7 channel disabled");
      chk(flag_done, 1, "R7 done flag");
      wr(RA_CMD, 1);
      chk(stop_busy, 0, "R7 stop ignored while disabled");
      drain();
   endtask

   task automatic t_flush();
      wr(RA_FLAG, 2);
      chk(flag_done, 0, "R10 done flag cleared");
      wr(RA_RUN, 1);
      push(1'b0);
      wr(RA_CMD, 2);
      chk(flush_busy, 1, "R8 flush pending");
      push(1'b1);
      tick();
      chk(flush_busy, 0, "R8 flush completes");
      chk(flag_done, 1, "R8 done flag from flush");
      chk(run_en, 1, "R8 flush keeps channel enabled");
      drain();
      push(1'b0);
      wr(RA_CMD, 1);
      wr(RA_CMD, 2);
      chk(flush_busy, 0, "R8 flush ignored during stop");
      chk(stop_busy, 1, "R8 stop still pending");
      push(1'b1);
      tick();
      chk(run_en, 0, "R8 stop finished");
      drain();
      wr(RA_RUN, 1);
      push(1'b0);
      wr(RA_CMD, 2);
      chk(flush_busy, 1, "R8 flush pending again");
      wr(RA_CMD, 1);
      chk(flush_busy, 0, "R8 stop cancels flush");
      chk(stop_busy, 1, "R8 stop taken");
      push(1'b1);
      tick();
      drain();
      wr(RA_RUN, 1);
      push(1'b0);
      wr(RA_CMD, 3);
      chk({stop_busy, flush_busy}, 2'b10, "R8 joint write keeps stop only");
      push(1'b1);
      tick();
      drain();
   endtask

   task automatic t_warm();
      logic [31:0] wp;
      wr(RA_RUN, 1);
      push(1'b0);
      wr(RA_CMD, 1);
      wp = wr_ptr;
      wr(RA_CMD, 4);
      chk(run_en, 0, "R9 warm reset disables");
      chk(stop_busy, 0, "R9 warm reset clears stop");
      chk(wr_ptr, wp, "R9 pointer kept");
      drain();
   endtask

   task automatic t_len();
      wr(RA_RPTR, 0);
      wr(RA_WPTR, 0);
      wr(RA_LEN, 0);
      wr(RA_LEN, 300);
      wr(RA_RUN, 1);
      for (int i = 0; i < 3; i++) push(1'b1);
      chk(wr_ptr, 3, "R12 offset before end");
      push(1'b1);
      chk(wr_ptr, 32'h8000_0000, "R12 bad length writes ignored");
      wr(RA_RUN, 0);
      wr(RA_RPTR, 32'h8000_0000);
      wr(RA_WPTR, 32'h8000_0002);
      chk(wr_ptr, 32'h8000_0002, "R12 write pointer load");
      chk(valid_cnt, 2, "R12 count after write pointer load");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_fill();
      t_halt();
      t_stop();
      t_flush();
      t_warm();
      t_len();
      repeat (2) tick();
      if (!done_run) begin
         done_run = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_run) begin
         done_run = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule